// File: doc/BRIEF.md
# Shared Address Latch Front End for a Two-Bank Sound Register File

This block sits between a host byte bus and the register file of a sound generator that is split into two banks, called part 1 and part 2. The host reaches the block through four byte-wide ports that are picked by a two-bit offset. Offset 0 is the address port of part 1 and offset 2 is the address port of part 2. Offsets 1 and 3 are the two data ports.

Both banks share one address latch. A write to an address port stores the register number. It also stores one bank bit, which records the address port that took the write. A later write to either data port sends a one-clock register write strobe to the bank and register held in the latch. The data port that received the write has no say in the bank. For example, an address written at offset 0 followed by data written at offset 2's neighbour, offset 3, still lands in part 1. The latch is not changed by data writes, so a run of data writes all update the same register. Every read, at any offset, returns the status byte that the host side of the chip supplies.

Top module: `sndbus_front`

## Requirements
- R1: While and after reset, `wr_stb` is 0 and `bus_rdata` is 0. The latch then holds part 1, register 0, so a data write made before any address write targets `wr_part` = 0 and `wr_reg` = 0.
- R2: A write at offset 0 stores `bus_wdata` as the register number and sets the bank bit to 0 (part 1).
- R3: A write at offset 2 stores `bus_wdata` as the register number and sets the bank bit to 1 (part 2).
- R4: A write at offset 1 or offset 3 produces a strobe whose `wr_part` and `wr_reg` equal the latched values. The data port offset does not affect `wr_part`.
- R5: A data write that is sampled at clock edge k drives `wr_stb` high for exactly the one cycle between edges k and k+1. During that cycle `wr_data` equals the written byte. An address write given at edge k is already used by a data write at edge k+1.
- R6: Data writes leave the latch unchanged. Consecutive data writes with no address write in between all carry the same `wr_part` and `wr_reg`.
- R7: A read (`bus_rd` = 1) at any offset sampled at edge k makes `bus_rdata` equal `status_in` from edge k onward, and the value holds until the next read. Reads change neither the latch nor `wr_stb`.
- R8: An address write produces no strobe. `wr_stb` is 1 only in the cycle after a data write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write request, sampled at each rising edge |
| bus_rd | input | 1 | Host read request, sampled at each rising edge |
| bus_ofs | input | OFS_W (2) | Port offset: bit 0 selects data (1) or address (0), bit 1 selects part 2 (1) or part 1 (0) for address ports |
| bus_wdata | input | DATA_W (8) | Host write byte |
| bus_rdata | output | DATA_W (8) | Registered status byte returned on reads |
| status_in | input | DATA_W (8) | Status byte from the core |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_part | output | 1 | Target bank of the strobe: 0 for part 1, 1 for part 2 |
| wr_reg | output | REG_W (8) | Target register number of the strobe |
| wr_data | output | DATA_W (8) | Data byte of the strobe |

## Verification
The hardest case to reach is a crossed pairing, where the address goes to one part's address port and the data goes to the other part's data port. A bench that always pairs ports by part cannot tell a design that takes the bank from the data port apart from this one. Directed tasks therefore make both crossings, offset 0 then 3 and offset 2 then 1, with register numbers that differ between the two. Back-to-back address and data writes in adjacent cycles confirm that the latch is updated before the next data write uses it. Reads placed between the writes confirm that status reads leave the latched target alone.

// File: rtl/sndbus_pkg.sv
package sndbus_pkg;

  // Kind of host access decoded from one bus cycle
  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_ADDR = 2'd1,
    ACC_DATA = 2'd2
  } acc_kind_e;

  // Bit positions inside the port offset that the decoder relies on
  localparam int unsigned OFS_DATA_BIT = 0;
  localparam int unsigned OFS_PART_BIT = 1;

endpackage

// File: rtl/sndbus_decode.sv
module sndbus_decode
  import sndbus_pkg::*;
#(
  parameter int unsigned OFS_W = 2
) (
  input  logic             wr,
  input  logic [OFS_W-1:0] ofs,
  output acc_kind_e        kind,
  output logic             part_sel
);

  always_comb begin
    kind = ACC_IDLE;
    if (wr) begin
      if (ofs[OFS_DATA_BIT]) kind = ACC_DATA;
      else                   kind = ACC_ADDR;
    end
  end

  // The part bit only matters for address ports; it is passed to the latch
  assign part_sel = ofs[OFS_PART_BIT];

endmodule

// File: rtl/sndbus_latch.sv
module sndbus_latch #(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             part_in,
  input  logic [REG_W-1:0] reg_in,
  output logic             part_q,
  output logic [REG_W-1:0] reg_q
);

  // One shared latch: register number plus the bank bit
  always_ff @(posedge clk) begin
    if (rst) begin
      part_q <= 1'b0;
      reg_q  <= '0;
    end else if (load) begin
      part_q <= part_in;
      reg_q  <= reg_in;
    end
  end

endmodule

// File: rtl/sndbus_strobe.sv
module sndbus_strobe #(
  parameter int unsigned REG_W  = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              part_in,
  input  logic [REG_W-1:0]  reg_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              stb,
  output logic              part_q,
  output logic [REG_W-1:0]  reg_q,
  output logic [DATA_W-1:0] data_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      stb    <= 1'b0;
      part_q <= 1'b0;
      reg_q  <= '0;
      data_q <= '0;
    end else begin
      stb <= fire;
      if (fire) begin
        part_q <= part_in;
        reg_q  <= reg_in;
        data_q <= data_in;
      end
    end
  end

endmodule

// File: rtl/sndbus_status.sv
module sndbus_status #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [DATA_W-1:0] status_in,
  output logic [DATA_W-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= status_in;
  end

endmodule

// File: rtl/sndbus_front.sv
module sndbus_front
  import sndbus_pkg::*;
#(
  parameter int unsigned OFS_W  = 2,
  parameter int unsigned REG_W  = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [OFS_W-1:0]  bus_ofs,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] status_in,
  output logic              wr_stb,
  output logic              wr_part,
  output logic [REG_W-1:0]  wr_reg,
  output logic [DATA_W-1:0] wr_data
);

  acc_kind_e        kind;
  logic             part_sel;
  logic             lat_part;
  logic [REG_W-1:0] lat_reg;
  logic [REG_W-1:0] addr_byte;

  // Register number taken from the low bits of the host byte
  localparam int unsigned NUM_W = (REG_W < DATA_W) ? REG_W : DATA_W;

  always_comb begin
    addr_byte = '0;
    addr_byte[NUM_W-1:0] = bus_wdata[NUM_W-1:0];
  end

  sndbus_decode #(.OFS_W(OFS_W)) decode_i (
    .wr       (bus_wr),
    .ofs      (bus_ofs),
    .kind     (kind),
    .part_sel (part_sel)
  );

  sndbus_latch #(.REG_W(REG_W)) latch_i (
    .clk     (clk),
    .rst     (rst),
    .load    (kind == ACC_ADDR),
    .part_in (part_sel),
    .reg_in  (addr_byte),
    .part_q  (lat_part),
    .reg_q   (lat_reg)
  );

  sndbus_strobe #(.REG_W(REG_W), .DATA_W(DATA_W)) strobe_i (
    .clk     (clk),
    .rst     (rst),
    .fire    (kind == ACC_DATA),
    .part_in (lat_part),
    .reg_in  (lat_reg),
    .data_in (bus_wdata),
    .stb     (wr_stb),
    .part_q  (wr_part),
    .reg_q   (wr_reg),
    .data_q  (wr_data)
  );

  sndbus_status #(.DATA_W(DATA_W)) status_i (
    .clk       (clk),
    .rst       (rst),
    .rd        (bus_rd),
    .status_in (status_in),
    .rdata     (bus_rdata)
  );

endmodule

// File: rtl/sndbus_front_chk.sv
module sndbus_front_chk #(
  parameter int unsigned OFS_W  = 2,
  parameter int unsigned REG_W  = 8,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [OFS_W-1:0]  bus_ofs,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] status_in,
  input logic              wr_stb,
  input logic              wr_part,
  input logic [REG_W-1:0]  wr_reg,
  input logic [DATA_W-1:0] wr_data
);

  logic is_data;
  logic is_addr;
  assign is_data = bus_wr &&  bus_ofs[0];
  assign is_addr = bus_wr && !bus_ofs[0];

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !wr_stb); // R1

  AST_STB_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
    is_data |=> (wr_stb && wr_data == $past(bus_wdata))); // R5

  AST_NO_STB_ON_ADDR: assert property (@(posedge clk) disable iff (rst)
    !is_data |=> !wr_stb); // R8

  AST_PART_FROM_ADDR: assert property (@(posedge clk) disable iff (rst)
    is_addr ##1 is_data |=> (wr_part == $past(bus_ofs[1], 2))); // R4

  AST_READ_STATUS: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> (bus_rdata == $past(status_in))); // R7

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R7

  AST_REG_KEPT: assert property (@(posedge clk) disable iff (rst)
    wr_stb && is_data && !$past(is_addr) |=> (wr_reg == $past(wr_reg) && wr_part == $past(wr_part))); // R6

endmodule

bind sndbus_front sndbus_front_chk #(
  .OFS_W(OFS_W), .REG_W(REG_W), .DATA_W(DATA_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_ofs   (bus_ofs),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .status_in (status_in),
  .wr_stb    (wr_stb),
  .wr_part   (wr_part),
  .wr_reg    (wr_reg),
  .wr_data   (wr_data)
);

// File: tb/sndbus_front_tb_top.sv
module sndbus_front_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [1:0] bus_ofs = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [7:0] status_in = 8'h00;
  logic       wr_stb;
  logic       wr_part;
  logic [7:0] wr_reg;
  logic [7:0] wr_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sndbus_front dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_ofs(bus_ofs),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .status_in(status_in),
    .wr_stb(wr_stb), .wr_part(wr_part), .wr_reg(wr_reg), .wr_data(wr_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // One bus write held for one edge; returns at the negedge after it
  task automatic bwrite(input logic [1:0] ofs, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_ofs = ofs; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [1:0] ofs);
    @(negedge clk);
    bus_rd = 1'b1; bus_ofs = ofs;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic expect_stb(input string tag, input int part, input int rg, input int d);
    chk({tag, " stb"},  wr_stb,  1);
    chk({tag, " part"}, wr_part, part);
    chk({tag, " reg"},  wr_reg,  rg);
    chk({tag, " data"}, wr_data, d);
  endtask

  task automatic t_reset;
    chk("R1 stb in reset", wr_stb, 0);
    chk("R1 rdata in reset", bus_rdata, 0);
    @(negedge clk); rst = 1'b0;
    chk("R1 stb after reset", wr_stb, 0);
    bwrite(2'd1, 8'hA5);
    expect_stb("R1 default target", 0, 0, 8'hA5);
  endtask

  task automatic t_straight;
    bwrite(2'd0, 8'h2B);
    chk("R8 no stb on addr write", wr_stb, 0);
    bwrite(2'd1, 8'h55);
    expect_stb("R2 part1 straight", 0, 8'h2B, 8'h55);
    bwrite(2'd2, 8'hB4);
    chk("R8 no stb on part2 addr", wr_stb, 0);
    bwrite(2'd3, 8'h66);
    expect_stb("R3 part2 straight", 1, 8'hB4, 8'h66);
  endtask

  task automatic t_cross;
    bwrite(2'd0, 8'h30);
    bwrite(2'd3, 8'h77);
    expect_stb("R4 addr0 data3", 0, 8'h30, 8'h77);
    bwrite(2'd2, 8'h41);
    bwrite(2'd1, 8'h88);
    expect_stb("R4 addr2 data1", 1, 8'h41, 8'h88);
  endtask

  task automatic t_pulse;
    bwrite(2'd1, 8'h12);
    expect_stb("R5 pulse", 1, 8'h41, 8'h12);
    @(negedge clk);
    chk("R5 pulse one cycle", wr_stb, 0);
    // address and data in adjacent cycles
    @(negedge clk);
    bus_wr = 1'b1; bus_ofs = 2'd2; bus_wdata = 8'hC3;
    @(negedge clk);
    chk("R8 no stb after back-to-back addr", wr_stb, 0);
    bus_ofs = 2'd1; bus_wdata = 8'h9E;
    @(negedge clk);
    bus_wr = 1'b0;
    expect_stb("R5 back-to-back", 1, 8'hC3, 8'h9E);
  endtask

  task automatic t_repeat;
    bwrite(2'd0, 8'h5D);
    for (int i = 0; i < 3; i++) begin
      bwrite((i % 2 == 0) ? 2'd3 : 2'd1, 8'(8'h10 + i));
      expect_stb("R6 repeated data", 0, 8'h5D, 8'h10 + i);
    end
  endtask

  task automatic t_read;
    for (int i = 0; i < 4; i++) begin
      status_in = 8'(8'hE0 + i);
      bread(2'(i));
      chk("R7 stb quiet on read", wr_stb, 0);
      status_in = 8'h00;
      @(negedge clk);
      chk("R7 status read", bus_rdata, 8'hE0 + i);
    end
    bwrite(2'd3, 8'hF0);
    expect_stb("R7 latch kept over reads", 0, 8'h5D, 8'hF0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_straight;
    t_cross;
    t_pulse;
    t_repeat;
    t_read;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule